// File: doc/BRIEF.md
# Two-Cycle 8x8 Multiplier with Fractional Modes

This block multiplies two 8-bit operands and returns a 16-bit product with a zero flag and a carry flag. A 3-bit mode code selects how each operand is read: both unsigned, both two's complement, or the first two's complement and the second unsigned. Bit 2 of the code selects fractional form, in which the integer product is shifted left by one bit. The product is meant for a fixed destination register pair, high byte in the upper register. Writing it back there is the caller's job.

A one-cycle `start` strobe captures the operands and the mode. The result and flags appear two rising edges later, together with a one-cycle `done` pulse. They then hold until the next result replaces them. The controller has two states. ST_IDLE waits for `start` and captures the operands (transition IDLE->CALC). ST_CALC forms the product, loads the result registers and raises `done` (transition CALC->IDLE). Without `start`, ST_IDLE stays in ST_IDLE. ST_CALC always returns to ST_IDLE after one cycle.

Top module: `frac_mult_unit`

## Requirements
- R1: After reset, `product` is 0, `flag_z` and `flag_c` are 0, and `done` is 0.
- R2: Mode code 0 (binary 000) multiplies both operands as unsigned. The result is `op_a*op_b` modulo 2^16.
- R3: Mode code 1 (001) multiplies both operands as two's complement. The result is the 16-bit two's complement product.
- R4: Mode code 2 (010) reads `op_a` as two's complement and `op_b` as unsigned. The result is the 16-bit two's complement product.
- R5: Mode codes 4, 5 and 6 (bit 2 set) use the signedness of codes 0, 1 and 2. The result is the integer product shifted left by one bit: bit 0 is 0 and the integer product's bit 15 is dropped.
- R6: `flag_c` equals bit 15 of the integer product, taken before any fractional shift.
- R7: `flag_z` is 1 exactly when the final 16-bit result is zero.
- R8: If `start` is sampled on a rising edge while the unit is idle, `product`, the flags and `done` update on the next rising edge. `done` is then high for exactly one cycle.
- R9: A `start` sampled while a multiply is in progress has no effect. The result belongs to the operands captured first, and only one `done` pulse is produced.
- R10: `product`, `flag_z` and `flag_c` keep their value in every cycle in which `done` is low. Changes on `op_a`, `op_b` or `mode` without `start` do not alter them.
- R11: Mode codes whose low two bits are 11 (3 and 7) use unsigned-by-unsigned signedness. Bit 2 still selects the fractional form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiply with the present operands and mode |
| mode | input | 3 | Bit 2: fractional form; bits 1:0: 00 unsigned, 01 signed, 10 signed-by-unsigned, 11 unsigned |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| product | output | 16 | Result, high byte in bits 15:8 |
| flag_z | output | 1 | Final result is zero |
| flag_c | output | 1 | Bit 15 of the unshifted product |
| done | output | 1 | One-cycle pulse when a new result is present |

## Verification
The hardest case to reach from the ports is a `start` that arrives during ST_CALC with different operands and mode on the pins. A correct design discards those values. A design that recaptures them, or restarts, gives a different product or a second `done` pulse. The bench holds `start` high for two consecutive edges and changes the operands between them. It then checks the single `done` pulse and the first product.

The fractional carry cases need operand pairs whose integer product has bit 15 set or sits right at it, for example -128 times -128 and 255 times 255. The sweep covers every first operand against a fixed spread of second operands that includes 0, 1, 0x7F, 0x80 and 0xFF, in all six modes.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CALC = 1'b1
    } fmul_state_e;

    // signedness selector, low two bits of the mode code
    localparam logic [1:0] SGN_UU = 2'b00;
    localparam logic [1:0] SGN_SS = 2'b01;
    localparam logic [1:0] SGN_SU = 2'b10;
endpackage

// File: rtl/fmul_ctrl.sv
module fmul_ctrl
    import fmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic capture,
    output logic load,
    output logic done
);
    fmul_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    capture = 1'b1;
                    state_d = ST_CALC;
                end
            end
            ST_CALC: begin
                load    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= load;
    end
endmodule

// File: rtl/fmul_core.sv
module fmul_core
    import fmul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [2:0]     mode,
    output logic [2*W-1:0] result,
    output logic           zero,
    output logic           carry
);
    localparam int PW = 2 * W;

    logic               a_sgn, b_sgn;
    logic signed [W:0]  ext_a, ext_b;
    logic signed [PW+1:0] full;
    logic [PW-1:0]      raw;

    always_comb begin
        unique case (mode[1:0])
            SGN_SS:  begin a_sgn = 1'b1; b_sgn = 1'b1; end
            SGN_SU:  begin a_sgn = 1'b1; b_sgn = 1'b0; end
            default: begin a_sgn = 1'b0; b_sgn = 1'b0; end
        endcase
        ext_a  = {a_sgn & a[W-1], a};
        ext_b  = {b_sgn & b[W-1], b};
        full   = ext_a * ext_b;
        raw    = full[PW-1:0];
        carry  = raw[PW-1];
        result = mode[2] ? {raw[PW-2:0], 1'b0} : raw;
        zero   = (result == '0);
    end
endmodule

// File: rtl/frac_mult_unit.sv
module frac_mult_unit
    import fmul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] product,
    output logic           flag_z,
    output logic           flag_c,
    output logic           done
);
    localparam int PW = 2 * W;

    logic          capture, load;
    logic [W-1:0]  a_q, b_q;
    logic [2:0]    mode_q;
    logic [PW-1:0] res_c;
    logic          z_c, c_c;

    fmul_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .capture (capture),
        .load    (load),
        .done    (done)
    );

    // operand capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= '0;
        end else if (capture) begin
            a_q    <= op_a;
            b_q    <= op_b;
            mode_q <= mode;
        end
    end

    fmul_core #(.W(W)) u_core (
        .a      (a_q),
        .b      (b_q),
        .mode   (mode_q),
        .result (res_c),
        .zero   (z_c),
        .carry  (c_c)
    );

    // result stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            product <= '0;
            flag_z  <= 1'b0;
            flag_c  <= 1'b0;
        end else if (load) begin
            product <= res_c;
            flag_z  <= z_c;
            flag_c  <= c_c;
        end
    end
endmodule

// File: rtl/fmul_checker.sv
module fmul_checker #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [2:0]     mode,
    input logic [2*W-1:0] product,
    input logic           flag_z,
    input logic           flag_c,
    input logic           done
);
    assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(product) && $stable(flag_z) && $stable(flag_c)));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (product == '0)));

    assert_frac_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mode[2], 2)) |-> !product[0]);
endmodule

bind frac_mult_unit fmul_checker #(.W(W)) u_fmul_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .product (product),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .done    (done)
);

// File: tb/tb_frac_mult_unit.sv
module tb_frac_mult_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [15:0] product;
    logic        flag_z, flag_c, done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    frac_mult_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .product(product),
        .flag_z(flag_z), .flag_c(flag_c), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // independent model from the requirement text
    function automatic void model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b,
                                  output logic [15:0] res, output logic z, output logic c);
        int av, bv, p;
        logic [15:0] raw;
        av = a; bv = b;
        if (m[1:0] == 2'b01) begin av = $signed(a); bv = $signed(b); end
        else if (m[1:0] == 2'b10) av = $signed(a);
        p   = av * bv;
        raw = p[15:0];
        c   = raw[15];
        res = m[2] ? {raw[14:0], 1'b0} : raw;
        z   = (res == 16'h0);
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m[1:0])
            2'b00:   return m[2] ? "R5/R2" : "R2";
            2'b01:   return m[2] ? "R5/R3" : "R3";
            2'b10:   return m[2] ? "R5/R4" : "R4";
            default: return "R11";
        endcase
    endfunction

    // one multiply with checks on timing, product and flags
    task automatic run_mul(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        logic [15:0] er; logic ez, ec;
        model(m, a, b, er, ez, ec);
        @(negedge clk);
        start = 1'b1; mode = m; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R8 early done", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R8 done", done, 1);
        check(product == er, req_of(m), product, er);
        check(flag_c == ec, "R6 carry", flag_c, ec);
        check(flag_z == ez, "R7 zero", flag_z, ez);
    endtask

    task automatic test_reset();
        check(product == 16'h0, "R1 product", product, 0);
        check(flag_z == 1'b0, "R1 flag_z", flag_z, 0);
        check(flag_c == 1'b0, "R1 flag_c", flag_c, 0);
        check(done == 1'b0, "R1 done", done, 0);
    endtask

    task automatic test_sweep(input logic [2:0] m);
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 19; j++) begin
                logic [7:0] bv;
                if (j < 16)       bv = 8'(j * 17);
                else if (j == 16) bv = 8'h80;
                else if (j == 17) bv = 8'h7F;
                else              bv = 8'h01;
                run_mul(m, 8'(i), bv);
            end
        end
    endtask

    task automatic test_corners();
        run_mul(3'd5, 8'h80, 8'h80);  // R5 R6: 0x4000 -> 0x8000, carry 0
        run_mul(3'd4, 8'hFF, 8'hFF);  // R6: raw 0xFE01, carry 1
        run_mul(3'd4, 8'h80, 8'h00);  // R7 zero
        run_mul(3'd4, 8'h80, 8'h02);  // R5 R7: raw 0x0100 -> 0x0200
        run_mul(3'd6, 8'h80, 8'hFF);  // R4 R5
    endtask

    // R9: second start during calculation with other operands is ignored
    task automatic test_busy_start();
        logic [15:0] er; logic ez, ec;
        model(3'd0, 8'h0C, 8'h0B, er, ez, ec);
        @(negedge clk);
        start = 1'b1; mode = 3'd0; op_a = 8'h0C; op_b = 8'h0B;
        @(negedge clk);
        mode = 3'd5; op_a = 8'hF3; op_b = 8'h77;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R9 done", done, 1);
        check(product == er, "R9 product", product, er);
        @(negedge clk);
        check(done == 1'b0, "R9 single done", done, 0);
        check(product == er, "R9 product kept", product, er);
    endtask

    // R10: result held while inputs move without start
    task automatic test_hold();
        logic [15:0] er; logic ez, ec;
        run_mul(3'd1, 8'hF0, 8'h10);
        model(3'd1, 8'hF0, 8'h10, er, ez, ec);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            mode = 3'(k); op_a = 8'(k * 37 + 1); op_b = 8'(k * 91 + 3);
            check(done == 1'b0, "R10 done", done, 0);
            check(product == er, "R10 product", product, er);
            check(flag_c == ec && flag_z == ez, "R10 flags", {flag_z, flag_c}, {ez, ec});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_sweep(3'd0);
        test_sweep(3'd1);
        test_sweep(3'd2);
        test_sweep(3'd4);
        test_sweep(3'd5);
        test_sweep(3'd6);
        test_corners();
        run_mul(3'd3, 8'hFF, 8'h80);  // R11 integer
        run_mul(3'd7, 8'hC1, 8'h9E);  // R11 fractional
        test_busy_start();
        test_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule